// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block sits behind the command/address pins of a two-rank DDR3 memory. On every rising clock edge it samples the two active-low chip selects, the three active-low command strobes (row strobe, column strobe, write enable), the bank address and the row/column address. One cycle later it presents one decoded command record.

The record carries:
- the command kind and the rank it addresses;
- the bank, the row or the column;
- the auto-precharge, all-bank and chop-to-4 qualifiers;
- the mode-register index and opcode.

Overloaded address bits are read according to the command. A10 is auto-precharge on reads and writes, and it is the all-bank flag on precharge. A12 is the on-the-fly chop request on reads and writes. A parameter selects x4 or x8 column mapping.

One internal state bit, the on-the-fly chop enable, is updated by a load-mode command to mode register 0. The output side is a valid-only stream with no ready. The memory command bus cannot be stalled, so there is no back-pressure, and a consumer must accept every cycle in which `out_valid` is high.

Top module: `dram_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, the outputs are held at their idle values: `out_valid`=0, `out_illegal`=0, `out_cmd`=1 (deselect), and every field is 0. The chop enable is cleared, which means fixed bursts of 8.
- R2: When both chip selects are sampled high, the outputs one cycle later are `out_cmd`=1 (deselect) and `out_valid`=0, whatever the other pins carry.
- R3: When exactly one chip select is sampled low, `out_rank` is 0 for `cs_n`=2'b10 and 1 for `cs_n`=2'b01.
- R4: When both chip selects are sampled low, the outputs one cycle later are `out_illegal`=1, `out_cmd`=9 and `out_valid`=0.
- R5: With one chip select low, the strobes {ras_n,cas_n,we_n} decode as follows:
  - 000 is load-mode, `out_cmd` 2;
  - 001 is refresh, `out_cmd` 3;
  - 010 is precharge, `out_cmd` 4;
  - 011 is activate, `out_cmd` 5;
  - 100 is write, `out_cmd` 6;
  - 101 is read, `out_cmd` 7;
  - 110 is calibration, `out_cmd` 8;
  - 111 is no-op, `out_cmd` 0.

  `out_valid` is 1 for every kind except no-op.
- R6: On activate, `out_row` equals the full sampled address and `out_bank` equals the sampled bank address.
- R7: On read or write, `out_col` is {A11, A9..A0} in x4 mode (11 bits) and A9..A0 in x8 mode (10 bits), and `out_bank` equals the bank address.
- R8: On read or write, `out_autopre` equals the sampled A10.
- R9: On precharge, A10 low gives `out_allbank`=0 with `out_bank`=BA, and A10 high gives `out_allbank`=1 with `out_bank`=0.
- R10: On read or write, `out_chop4` is 1 only when the chop enable is set and A12 was sampled low. While the enable is clear, `out_chop4` stays 0.
- R11: On load-mode, `out_mr` equals BA[1:0] and `out_op` equals the full sampled address.
- R12: A load-mode to register 0 sets the chop enable when its A[1:0] is 01 and clears it otherwise. Load-mode to any other register leaves it unchanged. The change applies from the next sampled command on.
- R13: Fields that do not belong to the decoded command are 0: `out_row` outside activate, `out_col` outside read/write, and `out_mr` and `out_op` outside load-mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 2 | Active-low chip selects, bit 0 = rank 0 |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| ba | input | BA_W (3) | Bank address / mode-register select |
| addr | input | ROW_W (15) | Row, column, qualifier and opcode bits |
| out_valid | output | 1 | A real command was decoded |
| out_cmd | output | 4 | Command kind code (see R5) |
| out_illegal | output | 1 | Both chip selects were low |
| out_rank | output | 1 | Addressed rank |
| out_bank | output | BA_W (3) | Addressed bank |
| out_row | output | ROW_W (15) | Row on activate |
| out_col | output | COL_W (11 x4 / 10 x8) | Column on read/write |
| out_autopre | output | 1 | Auto-precharge on read/write |
| out_allbank | output | 1 | Precharge targets all banks |
| out_chop4 | output | 1 | Burst chopped to 4 |
| out_mr | output | 2 | Mode register index on load-mode |
| out_op | output | ROW_W (15) | Mode register opcode on load-mode |

## Verification
The assertions assume that every input is stable around the rising edge, and that reset is released away from a clock edge. The bench meets both by changing every input and `rst_n` only on the falling edge. The properties also assume an address at least 13 bits wide, so that A12 exists, and the default parameters satisfy this. Chip-select patterns include the clash case on purpose. The chop enable is driven only through load-mode commands, including writes to registers other than register 0.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_REF   = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_WR    = 4'd6,
    CMD_RD    = 4'd7,
    CMD_ZQ    = 4'd8,
    CMD_BAD   = 4'd9
  } cmd_e;
endpackage

// File: rtl/dram_rank_sel.sv
module dram_rank_sel (
  input  logic [1:0] cs_n,
  output logic       sel_any,
  output logic       clash,
  output logic       rank
);
  // at least one rank addressed
  assign sel_any = ~&cs_n;
  // both ranks addressed at once
  assign clash   = ~|cs_n;
  // rank 1 when only its select is low
  assign rank    = cs_n[0];
endmodule

// File: rtl/dram_cmd_class.sv
module dram_cmd_class
  import dram_dec_pkg::*;
(
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e kind
);
  always_comb begin
    unique case ({ras_n, cas_n, we_n})
      3'b000:  kind = CMD_MRS;
      3'b001:  kind = CMD_REF;
      3'b010:  kind = CMD_PRE;
      3'b011:  kind = CMD_ACT;
      3'b100:  kind = CMD_WR;
      3'b101:  kind = CMD_RD;
      3'b110:  kind = CMD_ZQ;
      default: kind = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter bit X4_MODE = 1'b1,
  localparam int COL_W  = X4_MODE ? 11 : 10
) (
  input  logic [12:0]      a_lo,
  output logic [COL_W-1:0] col,
  output logic             a10,
  output logic             chop_req
);
  assign a10      = a_lo[10];
  // A12 low requests a chop to 4
  assign chop_req = ~a_lo[12];

  generate
    if (X4_MODE) begin : g_x4
      assign col = {a_lo[11], a_lo[9:0]};
    end else begin : g_x8
      logic unused_a11;
      assign unused_a11 = a_lo[11];
      assign col = a_lo[9:0];
    end
  endgenerate
endmodule

// File: rtl/dram_chop_mode.sv
module dram_chop_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mr0_wr,
  input  logic [1:0] bl_field,
  output logic       bc_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bc_en <= 1'b0;
    else if (mr0_wr) bc_en <= (bl_field == 2'b01);
  end
endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dram_dec_pkg::*;
#(
  parameter bit X4_MODE = 1'b1,
  parameter int ROW_W   = 15,
  parameter int BA_W    = 3,
  localparam int COL_W  = X4_MODE ? 11 : 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic             out_valid,
  output logic [3:0]       out_cmd,
  output logic             out_illegal,
  output logic             out_rank,
  output logic [BA_W-1:0]  out_bank,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col,
  output logic             out_autopre,
  output logic             out_allbank,
  output logic             out_chop4,
  output logic [1:0]       out_mr,
  output logic [ROW_W-1:0] out_op
);
  logic sel_any, clash, rank;
  cmd_e kind;
  logic [COL_W-1:0] col;
  logic a10, chop_req, bc_en, mr0_wr;

  dram_rank_sel u_rank (.cs_n(cs_n), .sel_any(sel_any), .clash(clash), .rank(rank));
  dram_cmd_class u_class (.ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind));
  dram_addr_map #(.X4_MODE(X4_MODE)) u_map (
    .a_lo(addr[12:0]), .col(col), .a10(a10), .chop_req(chop_req));

  // next-state of the output record
  cmd_e             cmd_n;
  logic             valid_n, illegal_n, rank_n, ap_n, all_n, chop_n;
  logic [BA_W-1:0]  bank_n;
  logic [ROW_W-1:0] row_n, op_n;
  logic [COL_W-1:0] col_n;
  logic [1:0]       mr_n;

  always_comb begin
    cmd_n = CMD_DESEL; valid_n = 1'b0; illegal_n = 1'b0; rank_n = 1'b0;
    bank_n = '0; row_n = '0; col_n = '0; ap_n = 1'b0; all_n = 1'b0;
    chop_n = 1'b0; mr_n = '0; op_n = '0;
    if (clash) begin
      cmd_n = CMD_BAD;
      illegal_n = 1'b1;
    end else if (sel_any) begin
      cmd_n   = kind;
      rank_n  = rank;
      valid_n = (kind != CMD_NOP);
      case (kind)
        CMD_ACT: begin
          bank_n = ba;
          row_n  = addr;
        end
        CMD_RD, CMD_WR: begin
          bank_n = ba;
          col_n  = col;
          ap_n   = a10;
          chop_n = bc_en & chop_req;
        end
        CMD_PRE: begin
          all_n  = a10;
          bank_n = a10 ? '0 : ba;
        end
        CMD_MRS: begin
          mr_n = ba[1:0];
          op_n = addr;
        end
        default: ;
      endcase
    end
  end

  assign mr0_wr = (cmd_n == CMD_MRS) && (ba[1:0] == 2'b00);

  dram_chop_mode u_chop (
    .clk(clk), .rst_n(rst_n), .mr0_wr(mr0_wr), .bl_field(addr[1:0]), .bc_en(bc_en));

  cmd_e cmd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL; out_valid <= 1'b0; out_illegal <= 1'b0;
      out_rank <= 1'b0; out_bank <= '0; out_row <= '0; out_col <= '0;
      out_autopre <= 1'b0; out_allbank <= 1'b0; out_chop4 <= 1'b0;
      out_mr <= '0; out_op <= '0;
    end else begin
      cmd_q <= cmd_n; out_valid <= valid_n; out_illegal <= illegal_n;
      out_rank <= rank_n; out_bank <= bank_n; out_row <= row_n;
      out_col <= col_n; out_autopre <= ap_n; out_allbank <= all_n;
      out_chop4 <= chop_n; out_mr <= mr_n; out_op <= op_n;
    end
  end
  assign out_cmd = cmd_q;
endmodule

// File: rtl/dram_cmd_decoder_chk.sv
module dram_cmd_decoder_chk
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 15,
  parameter int BA_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic             out_valid,
  input logic [3:0]       out_cmd,
  input logic             out_illegal,
  input logic             out_rank,
  input logic [BA_W-1:0]  out_bank,
  input logic [ROW_W-1:0] out_row,
  input logic             out_allbank,
  input logic             out_chop4,
  input logic             bc_en
);
  logic one_cs;
  assign one_cs = (cs_n == 2'b10) || (cs_n == 2'b01);

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b11) |=> (!out_valid && out_cmd == 4'd1));

  assert_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    one_cs |=> (out_rank == $past(cs_n[0])));

  assert_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b00) |=> (out_illegal && !out_valid));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_illegal}));

  assert_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (one_cs && {ras_n, cas_n, we_n} == 3'b011) |=>
      (out_row == $past(addr) && out_bank == $past(ba)));

  assert_preall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (one_cs && {ras_n, cas_n, we_n} == 3'b010 && addr[10]) |=>
      (out_allbank && out_bank == '0));

  assert_chop_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_chop4 |-> (out_cmd == 4'd6 || out_cmd == 4'd7));

  assert_chop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_en |=> !out_chop4);
endmodule

bind dram_cmd_decoder dram_cmd_decoder_chk #(.ROW_W(ROW_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .out_valid(out_valid), .out_cmd(out_cmd),
  .out_illegal(out_illegal), .out_rank(out_rank), .out_bank(out_bank),
  .out_row(out_row), .out_allbank(out_allbank), .out_chop4(out_chop4),
  .bc_en(bc_en));

// File: tb/tb_dram_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dram_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cs_n = 2'b11;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic        out_valid, out_illegal, out_rank, out_autopre, out_allbank, out_chop4;
  logic [3:0]  out_cmd;
  logic [2:0]  out_bank;
  logic [14:0] out_row, out_op;
  logic [10:0] out_col;
  logic [1:0]  out_mr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dram_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .out_valid(out_valid), .out_cmd(out_cmd),
    .out_illegal(out_illegal), .out_rank(out_rank), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col), .out_autopre(out_autopre),
    .out_allbank(out_allbank), .out_chop4(out_chop4), .out_mr(out_mr),
    .out_op(out_op));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive on the falling edge, observe just after the next rising edge
  task automatic issue(input logic [1:0] cs, input logic [2:0] rcw,
                       input logic [2:0] b, input logic [14:0] a);
    @(negedge clk);
    cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid, 0);
    chk("R1 cmd", out_cmd, 1);
    chk("R1 illegal", out_illegal, 0);
    chk("R1 row", out_row, 0);
  endtask

  task automatic t_deselect;
    issue(2'b11, 3'b101, 3'd2, 15'h1234);
    chk("R2 cmd", out_cmd, 1);
    chk("R2 valid", out_valid, 0);
    chk("R2 col", out_col, 0);
  endtask

  task automatic t_activate;
    issue(2'b10, 3'b011, 3'd5, 15'h6ABC);
    chk("R5 act cmd", out_cmd, 5);
    chk("R5 act valid", out_valid, 1);
    chk("R6 row", out_row, 'h6ABC);
    chk("R6 bank", out_bank, 5);
    chk("R3 rank0", out_rank, 0);
    chk("R13 col zero on act", out_col, 0);
    issue(2'b01, 3'b011, 3'd1, 15'h0007);
    chk("R3 rank1", out_rank, 1);
    chk("R6 row rank1", out_row, 7);
  endtask

  task automatic t_illegal;
    issue(2'b00, 3'b011, 3'd3, 15'h0100);
    chk("R4 illegal", out_illegal, 1);
    chk("R4 cmd", out_cmd, 9);
    chk("R4 valid", out_valid, 0);
  endtask

  task automatic t_readwrite;
    issue(2'b10, 3'b101, 3'd3, 15'h1D55);
    chk("R5 rd cmd", out_cmd, 7);
    chk("R7 x4 col", out_col, 'h555);
    chk("R7 rd bank", out_bank, 3);
    chk("R8 autopre on", out_autopre, 1);
    chk("R13 row zero on rd", out_row, 0);
    issue(2'b01, 3'b100, 3'd4, 15'h12AA);
    chk("R5 wr cmd", out_cmd, 6);
    chk("R7 wr col", out_col, 'h2AA);
    chk("R8 autopre off", out_autopre, 0);
    chk("R13 mr zero on wr", out_mr, 0);
  endtask

  task automatic t_precharge;
    issue(2'b10, 3'b010, 3'd6, 15'h0000);
    chk("R5 pre cmd", out_cmd, 4);
    chk("R9 single allbank", out_allbank, 0);
    chk("R9 single bank", out_bank, 6);
    issue(2'b10, 3'b010, 3'd6, 15'h0400);
    chk("R9 all allbank", out_allbank, 1);
    chk("R9 all bank", out_bank, 0);
  endtask

  task automatic t_misc;
    issue(2'b10, 3'b001, 3'd0, 15'h0);
    chk("R5 ref", out_cmd, 3);
    issue(2'b01, 3'b110, 3'd0, 15'h0400);
    chk("R5 zq", out_cmd, 8);
    issue(2'b10, 3'b111, 3'd2, 15'h0);
    chk("R5 nop cmd", out_cmd, 0);
    chk("R5 nop valid", out_valid, 0);
  endtask

  task automatic t_chop;
    issue(2'b10, 3'b101, 3'd0, 15'h0010);
    chk("R10 chop disabled", out_chop4, 0);
    issue(2'b10, 3'b000, 3'd0, 15'h0001);
    chk("R11 mrs cmd", out_cmd, 2);
    chk("R11 mr idx", out_mr, 0);
    chk("R11 opcode", out_op, 1);
    issue(2'b10, 3'b101, 3'd0, 15'h0010);
    chk("R12 chop after enable", out_chop4, 1);
    issue(2'b10, 3'b100, 3'd0, 15'h1010);
    chk("R10 A12 high bl8", out_chop4, 0);
    issue(2'b01, 3'b000, 3'd2, 15'h0000);
    chk("R11 mr2 idx", out_mr, 2);
    issue(2'b10, 3'b101, 3'd0, 15'h0010);
    chk("R12 mr2 leaves enable", out_chop4, 1);
    issue(2'b10, 3'b000, 3'd0, 15'h0000);
    issue(2'b10, 3'b101, 3'd0, 15'h0010);
    chk("R12 chop after disable", out_chop4, 0);
    chk("R13 op zero on rd", out_op, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_deselect();
    t_activate();
    t_illegal();
    t_readwrite();
    t_precharge();
    t_misc();
    t_chop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule